// File: doc/BRIEF.md
# Banked LED Matrix Driver Register File

This block is the register side of a serially programmed LED matrix driver. An external serial front end decodes the bus and presents each write transaction as a start pulse, a stream of bytes and a stop pulse. The block checks the first byte against its device address, takes the second byte as a register pointer and writes every later byte at the pointer, stepping the pointer by one per byte.

Register accesses go to one of several storage banks. A single command address, reachable from every bank, picks either a function bank or one of the frame banks. The function bank holds the shutdown control, the display mode byte and the index of the frame shown. Each frame bank holds a per-LED on/off bitmap and a per-LED duty byte. The outputs give the LED scanning stage the enable bit and duty byte of every LED in the displayed frame. In shutdown these outputs are forced to zero. Register writes are still accepted during shutdown.

Top module: `ledmx_regfile`

## Requirements
- R1: The address byte matches when it equals {0x74 | addr_strap, 1'b0}. The 7-bit address sits in bits 7:1, and bit 0 = 0 means write. A transaction whose address byte differs, including one with bit 0 = 1, changes no register and no output.
- R2: The first byte after a matching address byte loads the register pointer. Each later byte is written at the pointer, and the pointer then steps by one. The pointer is 8 bits wide, so it wraps from 0xFF to 0x00.
- R3: A write to address 0xFD selects a bank from any bank. The value 0x0B selects the function bank. A value below NUM_FRAMES selects that frame bank. Any other value leaves the selection unchanged.
- R4: In the function bank, bit 0 of a write to 0x0A sets the shutdown state. A 0 puts the device in shutdown and a 1 returns it to normal operation. in_shutdown reports 1 while the device is in shutdown.
- R5: In the function bank, a write to 0x00 sets disp_mode. A write to 0x01 sets the displayed frame from its low FRAME_W bits, and frame_shown reports that value. Writing to a frame bank that is not displayed does not change the outputs.
- R6: In a frame bank, addresses 0x00–0x11 are control bytes. The enable of LED i (0..143) is bit i mod 8 of control byte i/8. This is the same as bit (p−0x24) mod 8 of byte (p−0x24)/8 for duty address p.
- R7: In a frame bank, the duty byte of LED i is at address 0x24+i, which covers 0x24–0xB3. It appears on led_duty[8i+7:8i] when that frame is displayed.
- R8: While in shutdown, every led_en and led_duty bit is 0. Writes made during shutdown are stored and appear once shutdown ends.
- R9: After reset, all registers are zero and frame bank 0 is selected. The device is in shutdown, so in_shutdown is 1.
- R10: Writes to addresses with no storage change no output. These are the blink bytes 0x12–0x23, the range 0xB4–0xFC, 0xFE and 0xFF in a frame bank, and any function-bank address other than 0x00, 0x01 and 0x0A.
- R11: A start pulse restarts address matching even in the middle of a transaction. Bytes that arrive after a stop and before the next start are ignored. A start or stop pulse takes priority over a byte presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_strap | input | 2 | Low two device address bits from the board strap |
| txn_start | input | 1 | One-cycle pulse: a transaction begins |
| txn_stop | input | 1 | One-cycle pulse: the transaction ends |
| byte_valid | input | 1 | A received byte is on byte_data this cycle |
| byte_data | input | 8 | Received byte |
| in_shutdown | output | 1 | 1 while the device is in shutdown |
| disp_mode | output | 8 | Display mode byte |
| frame_shown | output | FRAME_W | Index of the displayed frame bank |
| led_en | output | 144 | Per-LED enable of the displayed frame |
| led_duty | output | 1152 | Per-LED duty byte, LED i in bits 8i+7:8i |

## Verification
The assertions check on every cycle that the pointer steps after each data byte and that a wrong address byte leads to the skip state. They also check that command writes move the bank selection or leave it alone, that shutdown follows bit 0 of its register, and that the outputs after reset are in the shutdown, all-zero state. Other behaviours can only be shown by the bench's scenarios: the bit mapping of the 144 enables, the placement of the duty bytes, whether a frame is displayed, that writes during shutdown are kept, that no-storage addresses have no effect, that all address and strap pairs decode correctly, that the pointer wraps, and that a mid-transaction restart behaves as specified.

// File: rtl/ledmx_pkg.sv
// Package: shared constants and the transaction phase type for the LED
// matrix register file. Assumes 8-bit register addresses and data.
package ledmx_pkg;
    localparam int        LED_COUNT  = 144;
    localparam logic [6:0] DEV_BASE  = 7'h74;
    localparam logic [7:0] CMD_ADDR  = 8'hFD;
    localparam logic [7:0] FUNC_SEL  = 8'h0B;
    localparam logic [7:0] FN_MODE   = 8'h00;
    localparam logic [7:0] FN_FRAME  = 8'h01;
    localparam logic [7:0] FN_SHUT   = 8'h0A;
    localparam logic [7:0] CTRL_LAST = 8'h11;
    localparam logic [7:0] PWM_BASE  = 8'h24;
    localparam logic [7:0] PWM_LAST  = 8'hB3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_PTR,
        PH_DATA,
        PH_SKIP
    } ledmx_phase_e;
endpackage

// File: rtl/ledmx_txn.sv
// Transaction decoder: follows start / byte / stop events, matches the
// device address byte, loads the register pointer and emits one write
// strobe per data byte, stepping the pointer after each.
// Assumes at most one of start, stop and byte events matters per cycle;
// start wins over stop, and both win over a byte.
module ledmx_txn
    import ledmx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr_strap,
    input  logic       txn_start,
    input  logic       txn_stop,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);
    ledmx_phase_e phase;
    logic [7:0]   ptr;
    logic [7:0]   dev_wr_byte;
    logic         byte_ev;

    // Expected address byte: strapped 7-bit address, write direction.
    assign dev_wr_byte = {DEV_BASE | {5'b0, addr_strap}, 1'b0};
    assign byte_ev     = byte_valid && !txn_start && !txn_stop;

    // Phase and pointer sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            ptr   <= '0;
        end else if (txn_start) begin
            phase <= PH_ADDR;
        end else if (txn_stop) begin
            phase <= PH_IDLE;
        end else if (byte_valid) begin
            case (phase)
                PH_ADDR: phase <= (byte_data == dev_wr_byte) ? PH_PTR : PH_SKIP;
                PH_PTR: begin
                    ptr   <= byte_data;
                    phase <= PH_DATA;
                end
                PH_DATA: ptr <= ptr + 8'd1;
                default: phase <= phase;
            endcase
        end
    end

    // Write strobe for data bytes of a matched transaction.
    assign wr_en   = byte_ev && (phase == PH_DATA);
    assign wr_addr = ptr;
    assign wr_data = byte_data;

    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && byte_ev) |=> (ptr == $past(ptr) + 8'd1));

    assert_skip_on_mismatch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ADDR && byte_ev && byte_data != dev_wr_byte) |=> (phase == PH_SKIP));
endmodule

// File: rtl/ledmx_func.sv
// Function bank and bank selector: holds the shutdown bit, display mode
// and displayed frame, and the current bank choice set by the command
// address. Assumes NUM_FRAMES is a power of two between 2 and 8.
module ledmx_func
    import ledmx_pkg::*;
#(
    parameter int NUM_FRAMES = 2,
    localparam int FRAME_W   = $clog2(NUM_FRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_addr,
    input  logic [7:0]         wr_data,
    output logic               bank_func,
    output logic [FRAME_W-1:0] bank_frame,
    output logic               shut_bit,
    output logic [7:0]         cfg_mode,
    output logic [FRAME_W-1:0] frame_reg
);
    localparam logic [8:0] NF = 9'(NUM_FRAMES);

    logic cmd_wr;
    logic fn_wr;
    logic frame_ok;

    assign cmd_wr   = wr_en && (wr_addr == CMD_ADDR);
    assign fn_wr    = wr_en && bank_func && (wr_addr != CMD_ADDR);
    assign frame_ok = ({1'b0, wr_data} < NF);

    // Bank selection from command writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_func  <= 1'b0;
            bank_frame <= '0;
        end else if (cmd_wr) begin
            if (wr_data == FUNC_SEL) begin
                bank_func <= 1'b1;
            end else if (frame_ok) begin
                bank_func  <= 1'b0;
                bank_frame <= wr_data[FRAME_W-1:0];
            end
        end
    end

    // Function bank register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shut_bit  <= 1'b0;
            cfg_mode  <= '0;
            frame_reg <= '0;
        end else if (fn_wr) begin
            case (wr_addr)
                FN_MODE:  cfg_mode  <= wr_data;
                FN_FRAME: frame_reg <= wr_data[FRAME_W-1:0];
                FN_SHUT:  shut_bit  <= wr_data[0];
                default:  ;
            endcase
        end
    end

    assert_func_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wr_data == FUNC_SEL) |=> bank_func);

    assert_bad_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wr_data != FUNC_SEL && !frame_ok) |=> ($stable(bank_func) && $stable(bank_frame)));

    assert_shut_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank_func && wr_addr == FN_SHUT) |=> (shut_bit == $past(wr_data[0])));
endmodule

// File: rtl/ledmx_frames.sv
// Frame banks: per frame, a 144-bit enable map written as 18 bytes and
// 144 duty bytes. Presents the enable map and duty bytes of the shown
// frame. Assumes wr_en is already qualified to frame-bank writes.
module ledmx_frames
    import ledmx_pkg::*;
#(
    parameter int NUM_FRAMES = 2,
    localparam int FRAME_W   = $clog2(NUM_FRAMES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [7:0]             wr_addr,
    input  logic [7:0]             wr_data,
    input  logic [FRAME_W-1:0]     wr_frame,
    input  logic [FRAME_W-1:0]     show_frame,
    output logic [LED_COUNT-1:0]   ctrl_out,
    output logic [LED_COUNT*8-1:0] duty_out
);
    logic [LED_COUNT-1:0] ctrl_q [NUM_FRAMES];
    logic [7:0]           duty_q [NUM_FRAMES][LED_COUNT];
    logic [7:0]           pidx;
    logic [7:0]           cbit;
    logic                 is_ctrl;
    logic                 is_pwm;

    assign pidx    = wr_addr - PWM_BASE;
    assign cbit    = {wr_addr[4:0], 3'b000};
    assign is_ctrl = (wr_addr <= CTRL_LAST);
    assign is_pwm  = (wr_addr >= PWM_BASE) && (wr_addr <= PWM_LAST);

    for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
        // Storage of frame f: enable bytes and duty bytes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q[f] <= '0;
                for (int i = 0; i < LED_COUNT; i++) duty_q[f][i] <= '0;
            end else if (wr_en && wr_frame == FRAME_W'(f)) begin
                if (is_ctrl) ctrl_q[f][cbit +: 8] <= wr_data;
                else if (is_pwm) duty_q[f][pidx] <= wr_data;
            end
        end
    end

    // Select the shown frame for the scanning stage.
    always_comb begin
        ctrl_out = ctrl_q[show_frame];
        for (int i = 0; i < LED_COUNT; i++) duty_out[i*8 +: 8] = duty_q[show_frame][i];
    end
endmodule

// File: rtl/ledmx_regfile.sv
// Top: banked register file of an LED matrix driver behind a byte-level
// write transaction interface. Routes decoded writes to the function or
// frame banks and forces the LED outputs off in shutdown.
// Assumes the serial front end delivers start/stop as one-cycle pulses.
module ledmx_regfile
    import ledmx_pkg::*;
#(
    parameter int NUM_FRAMES = 2,
    localparam int FRAME_W   = $clog2(NUM_FRAMES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             addr_strap,
    input  logic                   txn_start,
    input  logic                   txn_stop,
    input  logic                   byte_valid,
    input  logic [7:0]             byte_data,
    output logic                   in_shutdown,
    output logic [7:0]             disp_mode,
    output logic [FRAME_W-1:0]     frame_shown,
    output logic [LED_COUNT-1:0]   led_en,
    output logic [LED_COUNT*8-1:0] led_duty
);
    logic                   wr_en;
    logic [7:0]             wr_addr;
    logic [7:0]             wr_data;
    logic                   bank_func;
    logic [FRAME_W-1:0]     bank_frame;
    logic                   shut_bit;
    logic [7:0]             cfg_mode;
    logic [FRAME_W-1:0]     frame_reg;
    logic                   frame_wr;
    logic [LED_COUNT-1:0]   ctrl_out;
    logic [LED_COUNT*8-1:0] duty_out;

    ledmx_txn u_txn (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_strap (addr_strap),
        .txn_start  (txn_start),
        .txn_stop   (txn_stop),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    ledmx_func #(.NUM_FRAMES(NUM_FRAMES)) u_func (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .bank_func  (bank_func),
        .bank_frame (bank_frame),
        .shut_bit   (shut_bit),
        .cfg_mode   (cfg_mode),
        .frame_reg  (frame_reg)
    );

    // Frame-bank writes: not the command address, frame bank selected.
    assign frame_wr = wr_en && !bank_func && (wr_addr != CMD_ADDR);

    ledmx_frames #(.NUM_FRAMES(NUM_FRAMES)) u_frames (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (frame_wr),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_frame   (bank_frame),
        .show_frame (frame_reg),
        .ctrl_out   (ctrl_out),
        .duty_out   (duty_out)
    );

    // Output stage: shutdown blanks every LED.
    assign in_shutdown = !shut_bit;
    assign disp_mode   = cfg_mode;
    assign frame_shown = frame_reg;
    assign led_en      = shut_bit ? ctrl_out : '0;
    assign led_duty    = shut_bit ? duty_out : '0;

    assert_reset_state_R9: assert property (@(posedge clk)
        !rst_n |=> (in_shutdown && led_en == '0 && disp_mode == 8'h00 && frame_shown == '0));
endmodule

// File: tb/ledmx_regfile_bench.sv
// Bench: drives transactions, keeps an expected-state model derived from
// the requirements and compares every output bit group after each one.
module ledmx_regfile_bench;
    localparam int NF  = 2;
    localparam int LED = 144;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      addr_strap = 2'b00;
    logic            txn_start = 1'b0;
    logic            txn_stop = 1'b0;
    logic            byte_valid = 1'b0;
    logic [7:0]      byte_data = 8'h00;
    logic            in_shutdown;
    logic [7:0]      disp_mode;
    logic [0:0]      frame_shown;
    logic [LED-1:0]  led_en;
    logic [LED*8-1:0] led_duty;

    int errors = 0;
    int checks = 0;

    // Expected model.
    logic       m_run;
    logic [7:0] m_mode;
    logic       m_frame;
    logic       m_func;
    logic       m_bank;
    logic       m_en   [NF][LED];
    logic [7:0] m_duty [NF][LED];

    logic [7:0] tx_buf [0:199];

    always #4 clk = ~clk;

    ledmx_regfile #(.NUM_FRAMES(NF)) u_ledmx_regfile (
        .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap),
        .txn_start(txn_start), .txn_stop(txn_stop),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .in_shutdown(in_shutdown), .disp_mode(disp_mode),
        .frame_shown(frame_shown), .led_en(led_en), .led_duty(led_duty)
    );

    task automatic model_reset();
        m_run = 0; m_mode = 0; m_frame = 0; m_func = 0; m_bank = 0;
        for (int f = 0; f < NF; f++)
            for (int i = 0; i < LED; i++) begin
                m_en[f][i] = 0; m_duty[f][i] = 0;
            end
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'hFD) begin
            if (d == 8'h0B) m_func = 1;
            else if (d < NF) begin m_func = 0; m_bank = d[0]; end
        end else if (m_func) begin
            if (a == 8'h00) m_mode = d;
            else if (a == 8'h01) m_frame = d[0];
            else if (a == 8'h0A) m_run = d[0];
        end else if (a <= 8'h11) begin
            for (int b = 0; b < 8; b++) m_en[m_bank][a*8+b] = d[b];
        end else if (a >= 8'h24 && a <= 8'hB3) begin
            m_duty[m_bank][a-8'h24] = d;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        byte_valid = 1; byte_data = b;
        @(negedge clk);
        byte_valid = 0; byte_data = 0;
    endtask

    task automatic pulse_start();
        txn_start = 1; @(negedge clk); txn_start = 0;
    endtask

    task automatic pulse_stop();
        txn_stop = 1; @(negedge clk); txn_stop = 0;
    endtask

    // Full transaction: address byte then n bytes of tx_buf.
    task automatic send_txn(input logic [7:0] ab, input int n);
        logic [7:0] p;
        pulse_start();
        send_byte(ab);
        for (int k = 0; k < n; k++) send_byte(tx_buf[k]);
        pulse_stop();
        if (ab == {7'h74 | {5'b0, addr_strap}, 1'b0} && n > 0) begin
            p = tx_buf[0];
            for (int k = 1; k < n; k++) begin
                model_write(p, tx_buf[k]);
                p = p + 8'd1;
            end
        end
    endtask

    function automatic logic [7:0] dev_ab();
        return {7'h74 | {5'b0, addr_strap}, 1'b0};
    endfunction

    task automatic wr2(input logic [7:0] a, input logic [7:0] d);
        tx_buf[0] = a; tx_buf[1] = d;
        send_txn(dev_ab(), 2);
    endtask

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare all outputs against the model.
    task automatic check_all(input string req);
        logic [7:0] ed;
        logic       ee;
        chk(in_shutdown == !m_run, req, "in_shutdown", int'(in_shutdown), int'(!m_run));
        chk(disp_mode == m_mode, req, "disp_mode", int'(disp_mode), int'(m_mode));
        chk(frame_shown == m_frame, req, "frame_shown", int'(frame_shown), int'(m_frame));
        for (int i = 0; i < LED; i++) begin
            ee = m_run & m_en[m_frame][i];
            ed = m_run ? m_duty[m_frame][i] : 8'h00;
            chk(led_en[i] == ee, req, $sformatf("led_en[%0d]", i), int'(led_en[i]), int'(ee));
            chk(led_duty[i*8 +: 8] == ed, req, $sformatf("led_duty[%0d]", i),
                int'(led_duty[i*8 +: 8]), int'(ed));
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9: reset state
        check_all("R9");

        // R4: function bank, leave shutdown
        wr2(8'hFD, 8'h0B);
        wr2(8'h0A, 8'h01);
        check_all("R4");

        // R6 R7 R2: frame 0 full fill in single transactions
        wr2(8'hFD, 8'h00);
        tx_buf[0] = 8'h00;
        for (int k = 0; k < 18; k++) tx_buf[k+1] = 8'(k*37 + 5);
        send_txn(dev_ab(), 19);
        tx_buf[0] = 8'h24;
        for (int k = 0; k < 144; k++) tx_buf[k+1] = 8'(k*7 + 3);
        send_txn(dev_ab(), 145);
        check_all("R6_R7");

        // R5: fill frame 1 (command from frame bank), not shown yet
        wr2(8'hFD, 8'h01);
        tx_buf[0] = 8'h00;
        for (int k = 0; k < 18; k++) tx_buf[k+1] = 8'(k*91 + 200);
        send_txn(dev_ab(), 19);
        tx_buf[0] = 8'h24;
        for (int k = 0; k < 144; k++) tx_buf[k+1] = 8'(k*13 + 100);
        send_txn(dev_ab(), 145);
        check_all("R5_hidden");
        wr2(8'hFD, 8'h0B);
        wr2(8'h01, 8'h01);
        wr2(8'h00, 8'h18);
        check_all("R5_shown");

        // R10: blink and high addresses in frame 1; unused function regs
        wr2(8'hFD, 8'h01);
        tx_buf[0] = 8'h12;
        for (int k = 0; k < 18; k++) tx_buf[k+1] = 8'hFF;
        send_txn(dev_ab(), 19);
        tx_buf[0] = 8'hB4; tx_buf[1] = 8'h5A; tx_buf[2] = 8'hA5; tx_buf[3] = 8'h77;
        send_txn(dev_ab(), 4);
        wr2(8'hFE, 8'h99);
        wr2(8'hFD, 8'h0B);
        wr2(8'h06, 8'hFF);
        wr2(8'h02, 8'hFF);
        check_all("R10");

        // R3: invalid command keeps function bank; then 0x05 in frame bank
        wr2(8'hFD, 8'h05);
        wr2(8'h00, 8'h21);
        check_all("R3_func_kept");
        wr2(8'hFD, 8'h01);
        wr2(8'hFD, 8'h07);
        wr2(8'h24, 8'h55);
        check_all("R3_frame_kept");

        // R8: shutdown blanks, writes kept
        wr2(8'hFD, 8'h0B);
        wr2(8'h0A, 8'h00);
        check_all("R8_blank");
        wr2(8'hFD, 8'h00);
        tx_buf[0] = 8'h24; tx_buf[1] = 8'hAA; tx_buf[2] = 8'hBB;
        send_txn(dev_ab(), 3);
        wr2(8'h00, 8'hC3);
        wr2(8'hFD, 8'h0B);
        wr2(8'h01, 8'h00);
        check_all("R8_still_blank");
        wr2(8'h0A, 8'h01);
        check_all("R8_kept");

        // R1: read bit set is ignored
        tx_buf[0] = 8'h0A; tx_buf[1] = 8'h00;
        send_txn(dev_ab() | 8'h01, 2);
        check_all("R1_read");

        // R1: sweep strap and address low bits
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 4; a++) begin
                addr_strap = 2'(s);
                tx_buf[0] = 8'h00; tx_buf[1] = 8'(s*4 + a + 1);
                send_txn({7'h74 | 7'(a), 1'b0}, 2);
                check_all("R1_strap");
            end
        end
        addr_strap = 2'b10;

        // R2: pointer wrap 0xFE -> 0xFF -> 0x00 in function bank
        tx_buf[0] = 8'hFE; tx_buf[1] = 8'h11; tx_buf[2] = 8'h22; tx_buf[3] = 8'h42;
        send_txn(dev_ab(), 4);
        chk(disp_mode == 8'h42, "R2", "wrap disp_mode", int'(disp_mode), 8'h42);
        check_all("R2_wrap");

        // R11: restart mid-transaction with wrong address, stray bytes
        pulse_start();
        send_byte(dev_ab());
        send_byte(8'h00);
        send_byte(8'h33);
        model_write(8'h00, 8'h33);
        pulse_start();
        send_byte(8'hE0);
        send_byte(8'h00);
        send_byte(8'h77);
        pulse_stop();
        send_byte(8'h00);
        send_byte(8'h66);
        check_all("R11_restart");
        // R11: restart with matching address continues with a new pointer
        pulse_start();
        send_byte(dev_ab());
        send_byte(8'h0A);
        pulse_start();
        send_byte(dev_ab());
        send_byte(8'h00);
        send_byte(8'h5C);
        pulse_stop();
        model_write(8'h00, 8'h5C);
        check_all("R11_rematch");

        // R9: reset again clears everything
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
        @(negedge clk);
        check_all("R9_again");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule